// File: doc/BRIEF.md
# SIMD Unit Control and Status Register

This block holds the 32-bit control and status word of a floating-point SIMD unit. Software loads it through a write port and reads it back through a continuous read port. The arithmetic datapath presents a six-bit exception event vector every cycle. Each event bit is ORed into a sticky flag, and the flag stays set until software writes it clear. The block decodes the word into a rounding mode, a flush-to-zero enable, a denormals-are-zero enable and six exception suppress masks.

A write that sets any bit outside the supported-bit mask is dropped and produces a one-cycle fault pulse. The supported-bit mask is also driven on a port, so software can test whether the optional denormals-are-zero feature exists before it tries to use it. A parameter decides whether that feature is built. A trap pulse marks any event that arrives while its mask bit is clear.

Top module: `simd_csr`

## Requirements
- R1: After reset the register reads 0x0000_1F80: all six masks set, rounding 00, every flag clear, and bits 6 and 15 clear.
- R2: The layout is as follows. Bits [5:0] are the flags, in the order invalid, denormal, divide-by-zero, overflow, underflow, precision. Bit 6 is denormals-are-zero. Bits [12:7] are the masks, in the same exception order. Bits [14:13] are the rounding control. Bit 15 is flush-to-zero. The decoded outputs follow the register contents.
- R3: Rounding output encoding: 00 is nearest, 01 is toward negative, 10 is toward positive, 11 is toward zero.
- R4: An event bit sets its flag on the next clock edge. The flag stays set in later cycles without events, until a write clears it.
- R5: When a write and events occur in the same cycle, the register takes the write value ORed with the events in bits [5:0].
- R6: A write that sets any bit outside the feature mask leaves the register unchanged. The fault output is high for exactly the following cycle. Events in that cycle are still ORed into the flags.
- R7: The feature mask output is 0x0000_FFBF when HAS_DAZ=0 and 0x0000_FFFF when HAS_DAZ=1. With HAS_DAZ=0, a write that sets bit 6 faults.
- R8: The trap output is high in the cycle after any event bit arrives whose mask bit in the current register is 0. Otherwise it stays low.
- R9: A legal write updates the register on the next edge. A cycle with no write and no events leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value to load |
| rd_data | output | 32 | Current register contents |
| exc_evt | input | 6 | Exception events from the datapath for this cycle |
| feat_mask | output | 32 | Writable-bit mask |
| wr_fault | output | 1 | One-cycle pulse after a rejected write |
| trap | output | 1 | One-cycle pulse after an unmasked event |
| round_mode | output | 2 | Rounding control |
| flush_zero | output | 1 | Flush-to-zero enable |
| daz | output | 1 | Denormals-are-zero enable |
| exc_mask | output | 6 | Exception suppress masks |

## Verification
The assertions assume that `exc_evt` and `wr_data` carry known values during any clock in which they matter. They also assume the register only ever holds bits inside the feature mask, which holds because the write port filters illegal writes. The stimulus drives both inputs from `$urandom`. About a third of the writes are forced illegal by setting a reserved bit, or bit 6 when the feature is absent. Events are drawn sparse so that flags can be seen staying set.

// File: rtl/simd_csr.sv
module simd_csr #(
  parameter bit HAS_DAZ = 1'b1,
  parameter int NEXC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic [NEXC-1:0] exc_evt,
  output logic [31:0]     feat_mask,
  output logic            wr_fault,
  output logic            trap,
  output logic [1:0]      round_mode,
  output logic            flush_zero,
  output logic            daz,
  output logic [NEXC-1:0] exc_mask
);
  localparam int MLO = NEXC + 1;
  localparam logic [31:0] RST_VAL = 32'h0000_1F80;

  logic [31:0] csr_q;
  logic        bad_wr;
  logic [31:0] base;

  assign feat_mask = HAS_DAZ ? 32'h0000_FFFF : 32'h0000_FFBF;
  assign bad_wr    = wr_en && ((wr_data & ~feat_mask) != 32'd0);
  assign base      = (wr_en && !bad_wr) ? wr_data : csr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q    <= RST_VAL;
      wr_fault <= 1'b0;
      trap     <= 1'b0;
    end else begin
      csr_q    <= base | {{(32-NEXC){1'b0}}, exc_evt};
      wr_fault <= bad_wr;
      trap     <= |(exc_evt & ~csr_q[MLO +: NEXC]);
    end
  end

  assign rd_data    = csr_q;
  assign round_mode = csr_q[14:13];
  assign flush_zero = csr_q[15];
  assign daz        = csr_q[6];
  assign exc_mask   = csr_q[MLO +: NEXC];

  // R6
  csr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q & ~feat_mask) == 32'd0);
  // R4
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((csr_q[NEXC-1:0] & $past(csr_q[NEXC-1:0])) == $past(csr_q[NEXC-1:0])));
  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> (csr_q[31:NEXC] == $past(csr_q[31:NEXC])) && wr_fault);
  // R8
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt == '0) |=> !trap);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && exc_evt == '0) |=> $stable(csr_q));
endmodule

// File: tb/simd_csr_bench.sv
module simd_csr_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [5:0] exc_evt = 0;
  logic [31:0] rd_data, feat_mask;
  logic wr_fault, trap, flush_zero, daz;
  logic [1:0] round_mode;
  logic [5:0] exc_mask;
  int nchk = 0, nerr = 0;
  logic [31:0] model;
  logic exp_fault, exp_trap;

  always #2.5 clk = ~clk;

  simd_csr #(.HAS_DAZ(1'b1)) u_simd_csr (.*);

  localparam logic [31:0] FMASK = 32'h0000_FFFF;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] next_val(logic [31:0] cur, logic we, logic [31:0] d, logic [5:0] e);
    logic [31:0] b;
    b = (we && ((d & ~FMASK) == 0)) ? d : cur;
    return b | {26'd0, e};
  endfunction

  task automatic step(logic we, logic [31:0] d, logic [5:0] e);
    wr_en = we; wr_data = d; exc_evt = e;
    exp_fault = we && ((d & ~FMASK) != 0);
    exp_trap  = |(e & ~model[12:7]);
    model = next_val(model, we, d, e);
    @(posedge clk); #1;
    wr_en = 0; exc_evt = 0;
    chk("R9/R5/R6 value", rd_data, model);
    chk("R6 fault", {31'd0, wr_fault}, {31'd0, exp_fault});
    chk("R8 trap", {31'd0, trap}, {31'd0, exp_trap});
    chk("R2 decode", {rd_data[15], rd_data[6], rd_data[12:7]}, {flush_zero, daz, exc_mask});
  endtask

  initial begin
    #50000; nerr++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst_n = 1; #1;
    model = 32'h0000_1F80;
    chk("R1 reset", rd_data, 32'h0000_1F80);
    chk("R7 feature mask", feat_mask, 32'h0000_FFFF);
    for (int m = 0; m < 4; m++) begin
      step(1, {16'd0, 1'b0, m[1:0], 13'h1F80}, 0);
      chk("R3 round", {30'd0, round_mode}, m);
    end
    step(0, 0, 6'b000100);
    step(0, 0, 0);
    chk("R4 sticky", {31'd0, rd_data[2]}, 1);
    step(1, 32'h0000_1F80, 6'b000001);
    chk("R5 write+event", rd_data, 32'h0000_1F81);
    step(1, 32'h0001_0000, 6'b100000);
    step(1, 32'h0000_0000, 6'b001000);
    step(1, 32'h0000_FFFF, 0);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = {16'd0, $urandom_range(0, 65535)};
      if ($urandom_range(0, 2) == 0) d[16 + $urandom_range(0, 15)] = 1'b1;
      step($urandom_range(0, 1), d,
           ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'd0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule